// File: doc/BRIEF.md
# Cache Miss Classification Table

This block sits beside a set-associative cache and labels every miss as either a conflict miss or a capacity miss. For each cache set it keeps one record: a few low bits of the tag of the line that was last evicted from that set, plus a valid bit. A miss whose low tag bits equal the record of its own set is a line that was recently thrown out of that set and is now wanted again, so it is a conflict miss. Any other miss is a capacity miss.

The cache controller drives two ports. The eviction port reports a replaced line by its set index and tag. The miss port reports a miss by its set index and tag. One clock after each miss strobe the block returns a registered verdict with a valid flag. Logic that acts on the verdict, such as a victim store, a prefetcher or an exclusion filter, sits outside this block and reads the verdict.

Top module: `miss_classifier`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `class_valid` and `class_conflict` are 0. Reset clears every set's record, including records written before the reset.
- R2: `class_valid` is 1 in the cycle after a rising edge that samples `miss_valid` high, and 0 after an edge that samples it low. `class_conflict` is 0 whenever `class_valid` is 0.
- R3: A miss is a conflict (`class_conflict` = 1) when its set's record is valid and the record equals bits [PTAG_W-1:0] of `miss_tag`.
- R4: A miss whose low PTAG_W tag bits differ from a valid record of its set is a capacity miss (`class_conflict` = 0).
- R5: A miss to a set that has had no eviction since reset is a capacity miss.
- R6: Only tag bits [PTAG_W-1:0] take part. Tags that differ only in bits above PTAG_W-1 still give a conflict.
- R7: An eviction replaces the set's record. The tag evicted before it no longer matches.
- R8: A miss lookup leaves the record unchanged. Repeated misses with the same tag give the same verdict.
- R9: When an eviction and a miss target the same set in the same cycle, the miss is judged against the record as it was before that eviction. The new record applies from the next cycle.
- R10: Each set's record is independent. An eviction to one set does not change the verdict for another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| evict_valid | input | 1 | An eviction is reported this cycle |
| evict_set | input | IDX_W | Set index of the evicted line |
| evict_tag | input | TAG_W | Tag of the evicted line |
| miss_valid | input | 1 | A miss is reported this cycle |
| miss_set | input | IDX_W | Set index of the miss |
| miss_tag | input | TAG_W | Tag of the missing line |
| class_valid | output | 1 | A verdict is present (one cycle after the miss) |
| class_conflict | output | 1 | 1 = conflict miss, 0 = capacity miss |

## Verification
Each verdict is due on the first rising edge after its miss strobe is sampled. An eviction takes effect for misses sampled from the following edge onward. The bench drives each cycle's inputs just after a rising edge and computes the expected verdict from its own record table before that edge's eviction is applied. It then compares both outputs 2 ns after the edge and only afterwards applies the eviction. Because this comparison runs on every clock, idle cycles are also checked for a low valid flag.

// File: rtl/miss_classifier.sv
module miss_classifier #(
  parameter int SETS   = 64,
  parameter int TAG_W  = 20,
  parameter int PTAG_W = 8,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evict_valid,
  input  logic [IDX_W-1:0]  evict_set,
  input  logic [TAG_W-1:0]  evict_tag,
  input  logic              miss_valid,
  input  logic [IDX_W-1:0]  miss_set,
  input  logic [TAG_W-1:0]  miss_tag,
  output logic              class_valid,
  output logic              class_conflict
);

  logic [PTAG_W-1:0] rec_tag [SETS];
  logic [SETS-1:0]   rec_vld;

  wire [PTAG_W-1:0] miss_ptag  = miss_tag[PTAG_W-1:0];
  wire [PTAG_W-1:0] evict_ptag = evict_tag[PTAG_W-1:0];
  wire              rec_hit    = rec_vld[miss_set] && (rec_tag[miss_set] == miss_ptag);

  wire unused_hi = ^{evict_tag[TAG_W-1:PTAG_W], miss_tag[TAG_W-1:PTAG_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_vld        <= '0;
      class_valid    <= 1'b0;
      class_conflict <= 1'b0;
    end else begin
      class_valid    <= miss_valid;
      class_conflict <= miss_valid && rec_hit;
      if (evict_valid) rec_vld[evict_set] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (evict_valid) rec_tag[evict_set] <= evict_ptag;
  end

endmodule

// File: rtl/miss_classifier_chk.sv
module miss_classifier_chk #(
  parameter int SETS   = 64,
  parameter int TAG_W  = 20,
  parameter int PTAG_W = 8,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evict_valid,
  input logic [IDX_W-1:0]  evict_set,
  input logic [TAG_W-1:0]  evict_tag,
  input logic              miss_valid,
  input logic [IDX_W-1:0]  miss_set,
  input logic [TAG_W-1:0]  miss_tag,
  input logic              class_valid,
  input logic              class_conflict
);

  logic              seen_ev;
  logic              ev_q;
  logic [IDX_W-1:0]  eset_q;
  logic [PTAG_W-1:0] etag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_ev <= 1'b0;
      ev_q    <= 1'b0;
      eset_q  <= '0;
      etag_q  <= '0;
    end else begin
      seen_ev <= seen_ev | evict_valid;
      ev_q    <= evict_valid;
      eset_q  <= evict_set;
      etag_q  <= evict_tag[PTAG_W-1:0];
    end
  end

  wire unused_chk = ^{evict_tag[TAG_W-1:PTAG_W]};

  assert_verdict_follows_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> class_valid);

  assert_verdict_needs_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    class_valid |-> $past(miss_valid));

  assert_conflict_implies_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    class_conflict |-> class_valid);

  assert_fresh_record_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q && miss_valid && miss_set == eset_q && miss_tag[PTAG_W-1:0] == etag_q) |=> class_conflict);

  assert_empty_table_capacity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !seen_ev) |=> !class_conflict);

  assert_outputs_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({class_valid, class_conflict}));

endmodule

bind miss_classifier miss_classifier_chk #(.SETS(SETS), .TAG_W(TAG_W), .PTAG_W(PTAG_W)) u_chk (.*);

// File: tb/miss_classifier_bench.sv
`timescale 1ns/1ps
module miss_classifier_bench;
  localparam int SETS = 64, TAG_W = 20, PTAG_W = 8, IDX_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evict_valid = 1'b0, miss_valid = 1'b0;
  logic [IDX_W-1:0] evict_set = '0, miss_set = '0;
  logic [TAG_W-1:0] evict_tag = '0, miss_tag = '0;
  logic class_valid, class_conflict;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit mdl_v [SETS];
  int mdl_t [SETS];

  always #5 clk = ~clk;

  miss_classifier u_miss_classifier (.*);

  task automatic check(input string rq, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t {valid,conflict} actual=%b expected=%b", rq, $time, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < SETS; i++) begin mdl_v[i] = 1'b0; mdl_t[i] = 0; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; evict_valid = 1'b0; miss_valid = 1'b0;
    repeat (3) @(posedge clk);
    #2 check("R1", {class_valid, class_conflict}, 2'b00);
    clear_model();
    rst_n = 1'b1;
  endtask

  task automatic cyc(input bit ev, input int es, input int et,
                     input bit mv, input int ms, input int mt, input string rq);
    bit ec;
    evict_valid = ev; evict_set = es[IDX_W-1:0]; evict_tag = et[TAG_W-1:0];
    miss_valid  = mv; miss_set  = ms[IDX_W-1:0]; miss_tag  = mt[TAG_W-1:0];
    ec = mv && mdl_v[ms] && (mdl_t[ms] == (mt % (1 << PTAG_W)));
    @(posedge clk);
    #2 check(rq, {class_valid, class_conflict}, {mv, ec});
    if (ev) begin mdl_v[es] = 1'b1; mdl_t[es] = et % (1 << PTAG_W); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_model();
    do_reset();
    cyc(0,0,0, 0,0,0, "R2");
    cyc(0,0,0, 1,5,'h12345, "R5");
    cyc(1,5,'h00A7, 0,0,0, "R2");
    cyc(0,0,0, 1,5,'h000A7, "R3");
    cyc(0,0,0, 1,5,'hFFFA7, "R6");
    cyc(0,0,0, 1,5,'h000A8, "R4");
    cyc(0,0,0, 1,5,'h000A7, "R8");
    cyc(0,0,0, 1,5,'h000A7, "R8");
    cyc(1,5,'h0033, 1,5,'h00033, "R9");
    cyc(0,0,0, 1,5,'h00033, "R9");
    cyc(0,0,0, 1,5,'h000A7, "R7");
    cyc(1,9,'h0055, 1,9,'h00055, "R9");
    cyc(1,6,'h0033, 1,5,'h00033, "R10");
    cyc(0,0,0, 1,6,'h00033, "R10");
    cyc(0,0,0, 1,7,'h00033, "R10");
    cyc(1,63,'h01FF, 0,0,0, "R2");
    cyc(0,0,0, 1,63,'h7F0FF, "R6");
    cyc(1,0,'h0000, 1,0,'h00000, "R5");
    cyc(0,0,0, 1,0,'h00100, "R3");
    do_reset();
    cyc(0,0,0, 1,5,'h00033, "R1");
    cyc(0,0,0, 1,63,'h000FF, "R1");
    for (int n = 0; n < 3000; n++)
      cyc($urandom_range(0,1), $urandom_range(0,7), $urandom_range(0,3) | ($urandom_range(0,4095) << 8),
          $urandom_range(0,1), $urandom_range(0,7), $urandom_range(0,3) | ($urandom_range(0,4095) << 8), "R3");
    cyc(0,0,0, 0,0,0, "R2");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule